// File: doc/BRIEF.md
# SATA Link Low-Power State Controller

This block decides when a SATA link leaves the active state for one of its two low-power states: Partial, which wakes quickly, and Slumber, which goes deeper. It works for either end of the link. A role input selects host behaviour or device behaviour. The block watches command-issue and command-complete strobes, the number of outstanding commands, and a one-microsecond tick. From these it tracks how long the link has had no work. It then drives a one-hot request to the PHY and a 2-bit code for the current link state. A latency translator can map that code to a service-latency requirement.

Entry rules depend on the role and on whether commands are outstanding. Between commands, a host moves to Partial in the cycle after the last completion. A device waits a configurable number of microseconds before doing the same, so that the host can move first. Either role moves to Slumber after a long idle interval. While a command is outstanding, a host never lowers the link. A device may enter Partial when it reports an internal delay estimate longer than the assumed system resume latency. Slumber is never used while work is outstanding. A command issue or a wake request returns the link to active and restarts the idle timer.

Top module: `sata_lpm_ctrl`

## Requirements
- R1: Out of reset the link state is active: link_state_o = 2'b00 and only req_active_o is high.
- R2: link_state_o encodes active as 2'b00, Partial as 2'b01 and Slumber as 2'b10. Exactly one of req_active_o, req_partial_o and req_slumber_o is high, and it matches the state.
- R3: In host role (role_dev_i=0) with Partial enabled, a cmd_done_i strobe seen while pend_cnt_i is zero moves the link from active to Partial on the next clock edge.
- R4: In device role (role_dev_i=1) with Partial enabled and no commands pending, the link stays active until PART_DEV_US microsecond ticks have been counted. It moves to Partial on the next edge after that count is reached.
- R5: In either role with Slumber enabled, the link enters Slumber once SLUMBER_US ticks have been counted with no commands pending.
- R6: In host role, while pend_cnt_i is non-zero, the link never leaves active on its own. This holds regardless of ticks or delay estimates.
- R7: In device role, while pend_cnt_i is non-zero, a delay estimate strobe (dly_vld_i) moves the link to Partial only when dly_us_i > RESUME_US. A value equal to or below RESUME_US has no effect.
- R8: While pend_cnt_i is non-zero, the link is never in Slumber on the following cycle. If pending work appears while the link is in Slumber, the link returns to active. Ticks with work pending do not advance the idle timer.
- R9: cmd_issue_i or wake_i returns the link to active on the next edge and clears the idle timer. Counting restarts from zero once the link is idle again.
- R10: With partial_en_i low, the link never enters Partial by any rule. With slumber_en_i low, it never enters Slumber.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| role_dev_i | input | 1 | 0 = host-initiated rules, 1 = device-initiated rules |
| partial_en_i | input | 1 | Allow Partial entry |
| slumber_en_i | input | 1 | Allow Slumber entry |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| cmd_issue_i | input | 1 | Command issued strobe |
| cmd_done_i | input | 1 | Command completed strobe |
| pend_cnt_i | input | CNT_W | Outstanding commands, already updated for this cycle's strobes |
| wake_i | input | 1 | Wake request, forces active |
| dly_vld_i | input | 1 | Device internal-delay estimate valid |
| dly_us_i | input | DLY_W | Expected internal delay in microseconds |
| req_active_o | output | 1 | PHY request: active |
| req_partial_o | output | 1 | PHY request: Partial |
| req_slumber_o | output | 1 | PHY request: Slumber |
| link_state_o | output | 2 | Current state code for latency translation |

## Verification
The assertions check several rules on every cycle. Issue and wake force the link to active. Pending work excludes Slumber. A host stays active during a command. A device below its idle threshold stays active. A delay estimate at or under the resume latency is ignored. The PHY request stays one-hot. The bench scenarios show the exact entry cycles after 4, 5, 9999 and 10000 counted ticks, and the restart of the timer after a wake. They also show the effect of each enable bit and the sweep of delay estimates around the resume threshold in both roles.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LS_ACTIVE  = 2'b00,
    LS_PARTIAL = 2'b01,
    LS_SLUMBER = 2'b10
  } link_state_e;
endpackage

// File: rtl/lpm_idle_timer.sv
module lpm_idle_timer #(
  parameter int LIMIT = 10000,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  output logic [TW-1:0] cnt_o
);
  localparam logic [TW-1:0] CMAX = TW'(LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (tick_i && cnt_o < CMAX) cnt_o <= cnt_o + 1'b1;
  end

  AST_TIMER_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CMAX); // R5
  AST_TIMER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R9
endmodule

// File: rtl/lpm_entry_decide.sv
module lpm_entry_decide
  import lpm_pkg::*;
#(
  parameter int TW          = 14,
  parameter int DLY_W       = 16,
  parameter int PART_DEV_US = 5,
  parameter int SLUMBER_US  = 10000,
  parameter int RESUME_US   = 100
) (
  input  link_state_e      cur_i,
  input  logic             role_dev_i,
  input  logic             partial_en_i,
  input  logic             slumber_en_i,
  input  logic             cmd_issue_i,
  input  logic             cmd_done_i,
  input  logic             pend_zero_i,
  input  logic             wake_i,
  input  logic [TW-1:0]    idle_cnt_i,
  input  logic             dly_vld_i,
  input  logic [DLY_W-1:0] dly_us_i,
  output link_state_e      nxt_o
);
  localparam logic [TW-1:0]    PART_T = TW'(PART_DEV_US);
  localparam logic [TW-1:0]    SLUM_T = TW'(SLUMBER_US);
  localparam logic [DLY_W-1:0] RES_T  = DLY_W'(RESUME_US);

  logic host_go, dev_idle_go, dev_inner_go;

  always_comb begin
    host_go      = !role_dev_i && cmd_done_i && pend_zero_i;
    dev_idle_go  = role_dev_i && pend_zero_i && (idle_cnt_i >= PART_T);
    dev_inner_go = role_dev_i && !pend_zero_i && dly_vld_i && (dly_us_i > RES_T);
    nxt_o = cur_i;
    if (wake_i || cmd_issue_i)
      nxt_o = LS_ACTIVE;
    else if (!pend_zero_i && cur_i == LS_SLUMBER)
      nxt_o = LS_ACTIVE;
    else if (pend_zero_i && slumber_en_i && idle_cnt_i >= SLUM_T)
      nxt_o = LS_SLUMBER;
    else if (cur_i == LS_ACTIVE && partial_en_i &&
             (host_go || dev_idle_go || dev_inner_go))
      nxt_o = LS_PARTIAL;
  end
endmodule

// File: rtl/sata_lpm_ctrl.sv
module sata_lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int DLY_W       = 16,
  parameter int PART_DEV_US = 5,
  parameter int SLUMBER_US  = 10000,
  parameter int RESUME_US   = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             role_dev_i,
  input  logic             partial_en_i,
  input  logic             slumber_en_i,
  input  logic             us_tick_i,
  input  logic             cmd_issue_i,
  input  logic             cmd_done_i,
  input  logic [CNT_W-1:0] pend_cnt_i,
  input  logic             wake_i,
  input  logic             dly_vld_i,
  input  logic [DLY_W-1:0] dly_us_i,
  output logic             req_active_o,
  output logic             req_partial_o,
  output logic             req_slumber_o,
  output logic [1:0]       link_state_o
);
  localparam int TW = $clog2(SLUMBER_US + 1);
  localparam logic [DLY_W-1:0] RES_T  = DLY_W'(RESUME_US);
  localparam logic [TW-1:0]    PART_T = TW'(PART_DEV_US);

  link_state_e state_q, state_d;
  logic [TW-1:0] idle_cnt;
  logic pend_zero, tmr_clr;

  assign pend_zero = (pend_cnt_i == '0);
  assign tmr_clr   = cmd_issue_i || wake_i || !pend_zero;

  lpm_idle_timer #(.LIMIT(SLUMBER_US)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .tick_i(us_tick_i),
    .cnt_o (idle_cnt)
  );

  lpm_entry_decide #(
    .TW(TW), .DLY_W(DLY_W), .PART_DEV_US(PART_DEV_US),
    .SLUMBER_US(SLUMBER_US), .RESUME_US(RESUME_US)
  ) u_decide (
    .cur_i       (state_q),
    .role_dev_i  (role_dev_i),
    .partial_en_i(partial_en_i),
    .slumber_en_i(slumber_en_i),
    .cmd_issue_i (cmd_issue_i),
    .cmd_done_i  (cmd_done_i),
    .pend_zero_i (pend_zero),
    .wake_i      (wake_i),
    .idle_cnt_i  (idle_cnt),
    .dly_vld_i   (dly_vld_i),
    .dly_us_i    (dly_us_i),
    .nxt_o       (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LS_ACTIVE;
    else         state_q <= state_d;
  end

  assign link_state_o  = state_q;
  assign req_active_o  = (state_q == LS_ACTIVE);
  assign req_partial_o = (state_q == LS_PARTIAL);
  assign req_slumber_o = (state_q == LS_SLUMBER);

  AST_REQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({req_active_o, req_partial_o, req_slumber_o})); // R2
  AST_WAKE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_issue_i || wake_i) |=> link_state_o == 2'b00); // R9
  AST_PEND_NO_SLUMBER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_cnt_i != '0) |=> link_state_o != 2'b10); // R8
  AST_HOST_INNER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!role_dev_i && pend_cnt_i != '0 && state_q == LS_ACTIVE) |=> state_q == LS_ACTIVE); // R6
  AST_DEV_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (role_dev_i && pend_zero && state_q == LS_ACTIVE && idle_cnt < PART_T)
      |=> state_q == LS_ACTIVE); // R4
  AST_RESUME_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (role_dev_i && !pend_zero && state_q == LS_ACTIVE && !(dly_vld_i && dly_us_i > RES_T))
      |=> state_q == LS_ACTIVE); // R7
  AST_NO_PARTIAL_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!partial_en_i && state_q != LS_PARTIAL) |=> state_q != LS_PARTIAL); // R10
endmodule

// File: tb/sata_lpm_ctrl_bench.sv
module sata_lpm_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst_n = 1'b0;
  logic role_dev = 1'b0, pen = 1'b1, sen = 1'b1, tick = 1'b0;
  logic issue = 1'b0, done = 1'b0, wake = 1'b0, dvld = 1'b0;
  logic [4:0] pend = '0;
  logic [15:0] dly = '0;
  logic ra, rp, rs;
  logic [1:0] ls;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  sata_lpm_ctrl u_sata_lpm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .role_dev_i(role_dev), .partial_en_i(pen),
    .slumber_en_i(sen), .us_tick_i(tick), .cmd_issue_i(issue), .cmd_done_i(done),
    .pend_cnt_i(pend), .wake_i(wake), .dly_vld_i(dvld), .dly_us_i(dly),
    .req_active_o(ra), .req_partial_o(rp), .req_slumber_o(rs), .link_state_o(ls)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(); tick = 1'b0; step();
    end
  endtask

  task automatic chk(string tag, logic [1:0] exp);
    logic [2:0] er;
    er = {exp == 2'b10, exp == 2'b01, exp == 2'b00};
    n_chk++;
    if (ls !== exp || {rs, rp, ra} !== er) begin
      n_fail++;
      $display("FAIL %s: state=%b req=%b expected state=%b req=%b", tag, ls, {rs, rp, ra}, exp, er);
    end
  endtask

  task automatic do_issue();
    issue = 1'b1; pend = pend + 1'b1; step(); issue = 1'b0;
  endtask

  task automatic do_done();
    done = 1'b1; pend = pend - 1'b1; step(); done = 1'b0;
  endtask

  task automatic do_wake();
    wake = 1'b1; step(); wake = 1'b0;
  endtask

  task automatic do_dly(int d);
    dvld = 1'b1; dly = 16'(d); step(); dvld = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: state=%b expected run to complete", ls);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 reset", 2'b00);
    rst_n = 1'b1; step();
    chk("R1 after release", 2'b00);

    // host between commands
    do_issue();          chk("R9 issue active", 2'b00);
    do_done();           chk("R3 host partial next cycle", 2'b01);
    ticks(9999);         chk("R5 host before slumber limit", 2'b01);
    ticks(1);            chk("R5 host slumber (R2 code 10)", 2'b10);

    // host within command
    do_issue();          chk("R9 issue leaves slumber", 2'b00);
    ticks(30);           chk("R6 host ticks within command", 2'b00);
    do_dly(5000);        chk("R6 host ignores delay estimate", 2'b00);
    do_done();           chk("R3 host partial (R2 code 01)", 2'b01);

    // device between commands
    role_dev = 1'b1;
    do_wake();           chk("R9 wake active", 2'b00);
    ticks(4);            chk("R4 device waits", 2'b00);
    ticks(1);            chk("R4 device partial at limit", 2'b01);
    ticks(9995);         chk("R5 device slumber", 2'b10);
    pend = 5'd1; step(); chk("R8 pending demotes slumber", 2'b00);
    pend = 5'd0;

    // device within command
    do_issue();
    do_dly(100);         chk("R7 delay equal to resume ignored", 2'b00);
    do_dly(101);         chk("R7 delay above resume", 2'b01);
    ticks(10010);        chk("R8 no slumber while pending", 2'b01);
    do_done();           chk("R8 stays partial on completion", 2'b01);
    ticks(4);            chk("R9 timer restarted by pending", 2'b01);

    // enables
    pen = 1'b0;
    do_wake();
    ticks(5);            chk("R10 device partial disabled", 2'b00);
    role_dev = 1'b0;
    do_issue(); do_done(); chk("R10 host partial disabled", 2'b00);
    sen = 1'b0;
    ticks(10001);        chk("R10 slumber disabled", 2'b00);
    pen = 1'b1; sen = 1'b1;

    // sweep of delay estimates around the resume threshold, both roles
    for (int r = 0; r < 2; r++) begin
      for (int d = 95; d <= 106; d++) begin
        role_dev = r[0];
        do_issue();
        do_dly(d);
        chk("R7 delay sweep", (r == 1 && d > 100) ? 2'b01 : 2'b00);
        do_done();
        if (r == 0) chk("R3 host sweep completion", 2'b01);
        do_wake();
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule